// File: doc/BRIEF.md
# Burst Dibit Transmit Port Controller

This block runs the serial data intake of a burst-mode pi/4 DQPSK baseband transmitter. An upstream source asks for a burst by raising a burst-enable line. The block answers by dropping `ready`. After a short, fixed lead it starts a gated transmit clock, which it divides down from the master clock. The source changes its serial bit on each rising transmit-clock edge. The block captures the bit on the following falling edge. It pairs consecutive bits into two-bit symbols and hands each symbol to the downstream modulator with a single-cycle strobe.

When the burst-enable line drops, the block finishes the symbol it is building. It then clocks a fixed tail of extra symbols to flush the shaping filter, returns `ready` high and waits for a fresh request. A flag marks the whole active burst so that an envelope ramp can follow it. Two mode pins select one of three behaviours:
- normal modulation;
- a frequency-test mode that holds I at zero and Q at positive full scale;
- reserved settings that produce no modulation.

A low power input puts everything to sleep, and the outputs are flagged as disabled.

Top module: `burst_port_ctrl`

## Requirements
- R1: A rise of `burst_en` (asynchronous, passed through a two-flop synchronizer) while `ready` is high makes `ready` low on the third rising `clk` edge after the rise.
- R2: `tx_clk` stays low for exactly LEAD_CYC (default 2) `clk` cycles after `ready` falls. It then toggles with period CLK_DIV `clk` cycles, high for the first half of each period.
- R3: `tx_data` is captured on the `clk` edge at which `tx_clk` goes from high to low, so a source that changes it right after a `tx_clk` rise is sampled correctly.
- R4: Two consecutive captured bits form one symbol: the first captured bit is `sym_dibit[1]` and the second is `sym_dibit[0]`. `sym_valid` pulses for one cycle right after the second bit is captured. The strobe is produced only in normal mode.
- R5: After `burst_en` falls, the symbol in progress is completed, then exactly 2*TAIL_SYMS (default 8) further `tx_clk` cycles run.
- R6: `ready` returns high, and `burst_active` low, on the `clk` edge that ends the last `tx_clk` period of the tail. `burst_active` is high exactly while a burst is running and `ready` is low outside sleep.
- R7: A new burst needs a low-to-high transition of the synchronized `burst_en` seen while `ready` is high. A rise that happens during the flush tail is ignored even if the line is then held high, and `ready` stays high.
- R8: With `pwr_on` low, on the next `clk` edge `tx_clk`, `ready`, `sym_valid`, `burst_active`, `mod_en` and `static_iq_en` are low and `out_off` is high. Any burst is abandoned. One edge after `pwr_on` returns high, `ready` is high and `out_off` low.
- R9: `mode_sel[0]` is the first mode pin and `mode_sel[1]` the second. 2'b00 is normal mode, with `mod_en` high. 2'b10 is frequency-test mode, with `mod_en` low, `static_iq_en` high, `static_i` zero, `static_q` equal to 2^(IQ_W-1)-1 and no `sym_valid`.
- R10: In frequency-test mode the burst handshake, `tx_clk` and `burst_active` behave exactly as in normal mode, so the envelope still ramps.
- R11: `mode_sel` values 2'b01 and 2'b11 are reserved: `mod_en` and `static_iq_en` are low and no `sym_valid` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on | input | 1 | Low selects sleep |
| burst_en | input | 1 | Asynchronous burst request |
| mode_sel | input | 2 | Mode pins: bit 0 first pin, bit 1 second pin |
| tx_data | input | 1 | Serial transmit data |
| ready | output | 1 | High while idle and awake |
| tx_clk | output | 1 | Gated, divided transmit clock |
| sym_valid | output | 1 | One-cycle symbol strobe |
| sym_dibit | output | 2 | Symbol: bit 1 first serial bit, bit 0 second |
| burst_active | output | 1 | Burst running (envelope gate) |
| out_off | output | 1 | Outputs flagged disabled (sleep) |
| mod_en | output | 1 | Phase modulation enabled |
| static_iq_en | output | 1 | Static I/Q level in force |
| static_i | output | IQ_W | Static I level |
| static_q | output | IQ_W | Static Q level |

## Verification
The bench builds the block with CLK_DIV = 4 and IQ_W = 8, keeping the default lead and tail. A divide of four puts the falling-edge capture two cycles away from the period boundary. A capture on the wrong edge therefore yields a wrong symbol in the scoreboard, and a boundary test on the wrong cycle shifts the measured distance between the last transmit-clock rise and the return of `ready`. The narrow I/Q width keeps the full-scale value a small number that is easy to check, and the default tail length exercises the full eight-cycle flush count.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } bp_state_e;

  // bit 0 = first mode pin, bit 1 = second mode pin
  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_RSV_A  = 2'b01,
    MD_FTEST  = 2'b10,
    MD_RSV_B  = 2'b11
  } bp_mode_e;

  function automatic bp_mode_e decode_mode(input logic [1:0] pins);
    return bp_mode_e'(pins);
  endfunction

  // transmit-clock cycles in the flush tail: two bits per symbol
  function automatic int unsigned tail_cycles(input int unsigned syms);
    return 2 * syms;
  endfunction

  // largest positive two's-complement value of a w-bit word
  function automatic logic [31:0] full_scale_pos(input int unsigned w);
    return (32'd1 << (w - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bp_txclk_gen.sv
module bp_txclk_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tx_clk,
  output logic fall_evt,
  output logic cyc_end
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] PH_FALL = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(HALF);

  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ph <= '0;
    else if (!run || ph == PH_LAST)  ph <= '0;
    else                             ph <= ph + 1'b1;
  end

  // high half first; the edge leaving the high half is the capture edge
  assign tx_clk   = run && (ph < PH_HALF);
  assign fall_evt = run && (ph == PH_FALL);
  assign cyc_end  = run && (ph == PH_LAST);
endmodule

// File: rtl/bp_dibit_shift.sv
module bp_dibit_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sample,
  input  logic       bit_in,
  input  logic       emit_en,
  output logic       sym_valid,
  output logic [1:0] sym_dibit,
  output logic       at_boundary
);
  logic half_q;
  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= 1'b0;
      first_q   <= 1'b0;
      sym_valid <= 1'b0;
      sym_dibit <= 2'b00;
    end else begin
      sym_valid <= 1'b0;
      if (clr) begin
        half_q <= 1'b0;
      end else if (sample) begin
        if (!half_q) begin
          first_q <= bit_in;
          half_q  <= 1'b1;
        end else begin
          sym_dibit <= {first_q, bit_in};
          sym_valid <= emit_en;
          half_q    <= 1'b0;
        end
      end
    end
  end

  assign at_boundary = !half_q;
endmodule

// File: rtl/bp_mode_dec.sv
module bp_mode_dec
  import bp_pkg::*;
#(
  parameter int unsigned IQ_W = 10
) (
  input  logic [1:0]      mode_pins,
  input  logic            asleep,
  output logic            mod_en,
  output logic            static_en,
  output logic [IQ_W-1:0] static_i,
  output logic [IQ_W-1:0] static_q
);
  localparam logic [IQ_W-1:0] FS_POS = IQ_W'(full_scale_pos(IQ_W));

  always_comb begin
    mod_en    = 1'b0;
    static_en = 1'b0;
    unique case (decode_mode(mode_pins))
      MD_NORMAL: mod_en    = !asleep;
      MD_FTEST:  static_en = !asleep;
      default:   ;
    endcase
  end

  assign static_i = '0;
  assign static_q = static_en ? FS_POS : '0;
endmodule

// File: rtl/burst_port_ctrl.sv
module burst_port_ctrl
  import bp_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEAD_CYC    = 2,
  parameter int unsigned TAIL_SYMS   = 4,
  parameter int unsigned IQ_W        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_on,
  input  logic            burst_en,
  input  logic [1:0]      mode_sel,
  input  logic            tx_data,
  output logic            ready,
  output logic            tx_clk,
  output logic            sym_valid,
  output logic [1:0]      sym_dibit,
  output logic            burst_active,
  output logic            out_off,
  output logic            mod_en,
  output logic            static_iq_en,
  output logic [IQ_W-1:0] static_i,
  output logic [IQ_W-1:0] static_q
);
  localparam int unsigned TAIL_CYC = tail_cycles(TAIL_SYMS);
  localparam int unsigned TW       = $clog2(TAIL_CYC + 1);
  localparam int unsigned LW       = $clog2(LEAD_CYC + 1);
  localparam logic [LW-1:0] LEAD_LAST = LW'(LEAD_CYC - 1);
  localparam logic [TW-1:0] TAIL_INIT = TW'(TAIL_CYC);
  localparam logic [TW-1:0] TAIL_ONE  = TW'(1);

  bp_state_e     state;
  logic [LW-1:0] lead_cnt;
  logic [TW-1:0] tail_left;
  logic          stop_pend;
  logic          tail_q;
  logic          sleep_q;
  logic          en_s;
  logic          en_d;

  // named internal events
  logic start_evt;
  logic run;
  logic fall_evt;
  logic cyc_end;
  logic at_boundary;
  logic emit_en;

  bp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(burst_en), .q(en_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d    <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      en_d    <= en_s;
      sleep_q <= !pwr_on;
    end
  end

  assign start_evt = en_s && !en_d && !sleep_q;
  assign run       = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lead_cnt  <= '0;
      tail_left <= '0;
      stop_pend <= 1'b0;
      tail_q    <= 1'b0;
    end else if (!pwr_on) begin
      state     <= ST_IDLE;
      lead_cnt  <= '0;
      tail_left <= '0;
      stop_pend <= 1'b0;
      tail_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_evt) begin
            state     <= ST_LEAD;
            lead_cnt  <= '0;
            stop_pend <= 1'b0;
            tail_q    <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (!en_s) stop_pend <= 1'b1;
          if (lead_cnt == LEAD_LAST) state <= ST_RUN;
          else                       lead_cnt <= lead_cnt + 1'b1;
        end
        ST_RUN: begin
          if (!en_s && !tail_q) stop_pend <= 1'b1;
          if (cyc_end) begin
            if (tail_q) begin
              if (tail_left == TAIL_ONE) begin
                state  <= ST_IDLE;
                tail_q <= 1'b0;
              end else begin
                tail_left <= tail_left - 1'b1;
              end
            end else if (at_boundary && stop_pend) begin
              tail_q    <= 1'b1;
              tail_left <= TAIL_INIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  bp_txclk_gen #(.DIV(CLK_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .tx_clk(tx_clk), .fall_evt(fall_evt), .cyc_end(cyc_end)
  );

  bp_mode_dec #(.IQ_W(IQ_W)) u_mode (
    .mode_pins(mode_sel), .asleep(sleep_q),
    .mod_en(mod_en), .static_en(static_iq_en),
    .static_i(static_i), .static_q(static_q)
  );

  assign emit_en = mod_en && pwr_on;

  bp_dibit_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr(!run), .sample(fall_evt),
    .bit_in(tx_data), .emit_en(emit_en),
    .sym_valid(sym_valid), .sym_dibit(sym_dibit), .at_boundary(at_boundary)
  );

  assign ready        = (state == ST_IDLE) && !sleep_q;
  assign burst_active = (state != ST_IDLE);
  assign out_off      = sleep_q;
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int unsigned LEAD_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic tx_clk,
  input logic burst_active,
  input logic sym_valid,
  input logic out_off,
  input logic mod_en,
  input logic static_iq_en,
  input logic fall_evt,
  input logic cyc_end
);
  localparam int unsigned CW = $clog2(LEAD_CYC + 2);
  localparam logic [CW-1:0] LEAD_V = CW'(LEAD_CYC);

  logic [CW-1:0] since_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  since_fall <= '0;
    else if (ready || out_off || !burst_active)  since_fall <= '0;
    else if (since_fall <= LEAD_V)               since_fall <= since_fall + 1'b1;
  end

  a_r2_lead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && since_fall < LEAD_V) |-> !tx_clk);

  a_r2_clk_start: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && since_fall == LEAD_V) |-> tx_clk);

  a_r3_strobe_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(fall_evt));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);

  a_r6_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!burst_active && !tx_clk));

  a_r6_ready_at_period_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !$past(out_off)) |-> $past(cyc_end));

  a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_off |-> (!ready && !tx_clk && !sym_valid && !burst_active));

  a_r9_strobe_needs_mod: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(mod_en));

  a_r11_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_en && static_iq_en));
endmodule

bind burst_port_ctrl bp_checker #(.LEAD_CYC(LEAD_CYC)) u_bp_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .tx_clk(tx_clk),
  .burst_active(burst_active), .sym_valid(sym_valid), .out_off(out_off),
  .mod_en(mod_en), .static_iq_en(static_iq_en),
  .fall_evt(fall_evt), .cyc_end(cyc_end)
);

// File: tb/test_burst_port_ctrl.sv
`timescale 1ns/1ps
module test_burst_port_ctrl;
  localparam int DIV  = 4;
  localparam int LEAD = 2;
  localparam int TAIL = 4;
  localparam int IQW  = 8;
  localparam int FSQ  = (1 << (IQW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b1;
  logic burst_en = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic tx_data = 1'b0;
  logic ready, tx_clk, sym_valid, burst_active, out_off, mod_en, static_iq_en;
  logic [1:0] sym_dibit;
  logic [IQW-1:0] static_i, static_q;

  int tests = 0;
  int fails = 0;
  int sym_seen = 0;
  logic [1:0] exp_q[$];

  always #2.5 clk = ~clk;

  burst_port_ctrl #(
    .CLK_DIV(DIV), .SYNC_STAGES(2), .LEAD_CYC(LEAD), .TAIL_SYMS(TAIL), .IQ_W(IQW)
  ) i_burst_port_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .burst_en(burst_en),
    .mode_sel(mode_sel), .tx_data(tx_data), .ready(ready), .tx_clk(tx_clk),
    .sym_valid(sym_valid), .sym_dibit(sym_dibit), .burst_active(burst_active),
    .out_off(out_off), .mod_en(mod_en), .static_iq_en(static_iq_en),
    .static_i(static_i), .static_q(static_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: new bit after each tx_clk rise, expected symbols pushed to the scoreboard
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit prev = 1'b0;
    bit par = 1'b0;
    logic first = 1'b0;
    forever begin
      @(negedge clk);
      if (!burst_active) par = 1'b0;
      if (tx_clk && !prev) begin
        logic b;
        b = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        tx_data = b;
        if (!par) begin
          first = b;
          par = 1'b1;
        end else begin
          if (mode_sel == 2'b00) exp_q.push_back({first, b});
          par = 1'b0;
        end
      end
      prev = tx_clk;
    end
  end

  // monitor: compare each strobed symbol against the scoreboard (R3 R4)
  initial begin
    forever begin
      @(negedge clk);
      if (sym_valid) begin
        sym_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected strobe", sym_dibit, -1);
        else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(sym_dibit == e, "R3 R4 symbol value", sym_dibit, e);
        end
      end
    end
  end

  task automatic burst(input logic [1:0] md, input int nsym, input bit again);
    int rises, post, cyc, last, s0, exps;
    bit prv, stayed;
    mode_sel = md;
    s0 = sym_seen;
    burst_en = 1'b1;
    @(negedge clk); chk(ready == 1'b1, "R1 ready high after 1 edge", ready, 1);
    @(negedge clk); chk(ready == 1'b1, "R1 ready high after 2 edges", ready, 1);
    @(negedge clk); chk(ready == 1'b0, "R1 ready low on third edge", ready, 0);
    chk(burst_active == 1'b1, "R10 burst_active during burst", burst_active, 1);
    if (md == 2'b10) begin
      chk(static_iq_en == 1'b1, "R9 ftest static enable", static_iq_en, 1);
      chk(static_i == '0, "R9 ftest I zero", static_i, 0);
      chk(static_q == IQW'(FSQ), "R9 ftest Q full scale", static_q, FSQ);
      chk(mod_en == 1'b0, "R9 ftest no modulation", mod_en, 0);
    end else if (md == 2'b00) begin
      chk(mod_en == 1'b1, "R9 normal mod_en", mod_en, 1);
    end else begin
      chk(mod_en == 1'b0 && static_iq_en == 1'b0, "R11 reserved outputs off",
          {mod_en, static_iq_en}, 0);
    end
    @(negedge clk); chk(tx_clk == 1'b0, "R2 lead gap", tx_clk, 0);
    @(negedge clk); chk(tx_clk == 1'b1, "R2 tx_clk starts", tx_clk, 1);
    rises = 1;
    prv = 1'b1;
    while (rises < 2 * nsym + 1) begin
      @(negedge clk);
      if (tx_clk && !prv) rises++;
      prv = tx_clk;
    end
    burst_en = 1'b0;
    post = 0; cyc = 0; last = 0;
    while (!ready && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (tx_clk && !prv) begin post++; last = cyc; end
      prv = tx_clk;
      if (again && post == 3) burst_en = 1'b1;
    end
    chk(post == 1 + 2 * TAIL, "R5 tail tx_clk cycles", post, 1 + 2 * TAIL);
    chk(cyc - last == DIV, "R6 ready at end of last period", cyc - last, DIV);
    chk(burst_active == 1'b0 && tx_clk == 1'b0, "R6 idle after tail",
        {burst_active, tx_clk}, 0);
    repeat (2) @(negedge clk);
    exps = (md == 2'b00) ? nsym + 1 + TAIL : 0;
    chk(sym_seen - s0 == exps, (md == 2'b00) ? "R4 symbol count" : "R9 R11 no strobes",
        sym_seen - s0, exps);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    if (again) begin
      stayed = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (!ready || tx_clk) stayed = 1'b0;
      end
      chk(stayed, "R7 tail request ignored", stayed, 1);
      burst_en = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic sleep_test();
    bit quiet;
    int guard;
    mode_sel = 2'b00;
    burst_en = 1'b1;
    guard = 0;
    while (!tx_clk && guard < 50) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    pwr_on = 1'b0;
    @(negedge clk);
    chk(tx_clk == 0 && ready == 0 && burst_active == 0 && sym_valid == 0,
        "R8 sleep stops activity", {tx_clk, ready, burst_active, sym_valid}, 0);
    chk(out_off == 1'b1, "R8 outputs flagged off", out_off, 1);
    chk(mod_en == 0 && static_iq_en == 0, "R8 mode outputs off in sleep",
        {mod_en, static_iq_en}, 0);
    burst_en = 1'b0;
    quiet = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (tx_clk || ready || !out_off) quiet = 1'b0;
    end
    chk(quiet, "R8 sleep holds", quiet, 1);
    pwr_on = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && out_off == 1'b0, "R8 wake to ready", {ready, out_off}, 2);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R6 reset ready high", ready, 1);
    chk(tx_clk == 0 && burst_active == 0 && sym_valid == 0 && out_off == 0,
        "R6 reset quiet", {tx_clk, burst_active, sym_valid, out_off}, 0);
    chk(mod_en == 1'b1, "R9 reset normal mode", mod_en, 1);
    burst(2'b00, 3, 1'b0);
    burst(2'b00, 5, 1'b1);
    burst(2'b00, 0, 1'b0);
    burst(2'b10, 2, 1'b0);
    mode_sel = 2'b01;
    @(negedge clk);
    chk(mod_en == 0 && static_iq_en == 0, "R11 mode 01 idle outputs", {mod_en, static_iq_en}, 0);
    mode_sel = 2'b11;
    @(negedge clk);
    chk(mod_en == 0 && static_iq_en == 0, "R11 mode 11 idle outputs", {mod_en, static_iq_en}, 0);
    burst(2'b01, 1, 1'b0);
    burst(2'b11, 1, 1'b0);
    sleep_test();
    burst(2'b00, 2, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule